// File: doc/BRIEF.md
# Duty Cycle Tracking PWM Combiner

This block turns a 4-bit step level into a digital pulse-width pattern on a fixed frame and merges it with an externally supplied PWM signal. The gate output is high only while both the external PWM and the digital pattern are high, so whichever duty cycle is smaller controls it. A short guaranteed pulse at the start of every frame is ORed on top, so the gate is never fully off. The digital pattern has a floor of 31.25% and rises in 6.25% steps up to 100%.

In the same frame the block counts how long the external PWM is high. At the frame boundary it compares that count with the digital duty and reports a direction: up, down or hold. An external step counter uses this direction to move the level. A rising external duty therefore passes straight through up to the 31.25% floor and then grows only as fast as the level is stepped. A falling external duty reaches the gate at once, because the AND is combinational.

A frame has 32 phases. Each `tick` pulse advances one phase, and the digital pattern works in slots of two phases, which gives 16 slots per frame.

Top module: `duty_track_gate`

## Requirements
- R1: Synchronous active-high `rst` puts the frame at phase 0, sets the active level to 0 and sets `cmp_dir` to 2'b00 (hold).
- R2: With active level k from 0 to 10, the digital pattern is high in slots 0 to 4+k (slot = phase/2), which is 5+k of 16 slots. Level 0 gives 31.25% and level 10 gives 93.75%.
- R3: Active levels 11 to 15 give a digital pattern that is high in all 16 slots (100%).
- R4: `level` is captured into the active level only on the `tick` that closes phase 31. Changes to `level` at any other time have no effect on the current frame.
- R5: In every phase except phase 0, `gate_out` equals `pwm_in` AND the digital pattern, in the same cycle with no register on the way.
- R6: In phase 0, `gate_out` is high whatever `pwm_in` is: one phase of 32, about 3.1%.
- R7: `pwm_in` is sampled at each `tick` and counted over the 32 phases of a frame. On the tick that closes phase 31, `cmp_dir` becomes 2'b01 if the count exceeds twice the active level's slot count, 2'b10 if it is below, and 2'b00 if it is equal. At all other times `cmp_dir` holds its value.
- R8: While `tick` is low, the phase does not advance and `cmp_dir` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Phase advance strobe |
| level | input | 4 | Requested step level |
| pwm_in | input | 1 | External PWM signal |
| gate_out | output | 1 | Combined gate PWM |
| cmp_dir | output | 2 | Compare result: 01 up, 10 down, 00 hold |

## Verification
The closing tick of phase 31 does three things in the same cycle: it latches the final `pwm_in` sample into the duty count, it updates `cmp_dir`, and it captures a new `level`. The bench drives a different `level` during the frame than at its close, and puts meaningful `pwm_in` values in phase 31. The per-phase gate checks of the next frame must then follow the newly captured level, and the direction must include the last sample. Phase 0 is also where the minimum pulse and the AND path meet. The bench judges it with `pwm_in` both low and high and expects the gate high in both cases.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    localparam int LVL_W       = 4;
    localparam int SLOT_W      = 4;
    localparam int SLOTS       = 1 << SLOT_W;
    localparam int PH_W        = SLOT_W + 1;
    localparam int CNT_W       = PH_W + 1;
    localparam int FLOOR_SLOTS = 5;

    typedef logic [LVL_W-1:0]  lvl_t;
    typedef logic [PH_W-1:0]   phase_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [SLOT_W:0]   slots_t;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DN   = 2'b10
    } dir_e;

    typedef struct packed {
        phase_t phase;
        lvl_t   lvl;
    } frame_t;

    // number of high slots in the digital pattern for a level
    function automatic slots_t hi_slots(lvl_t l);
        int n;
        n = int'(l) + FLOOR_SLOTS;
        if (n >= SLOTS) n = SLOTS;
        return slots_t'(n);
    endfunction

endpackage

// File: rtl/dtg_frame_seq.sv
module dtg_frame_seq
    import dtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  lvl_t   level,
    output frame_t fs_o,
    output logic   wrap_o
);

    localparam phase_t LAST_PH = phase_t'((1 << PH_W) - 1);

    frame_t fs_q;

    assign wrap_o = tick && (fs_q.phase == LAST_PH);
    assign fs_o   = fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q.phase <= '0;
            fs_q.lvl   <= '0;
        end else if (tick) begin
            fs_q.phase <= fs_q.phase + 1'b1;
            if (wrap_o) fs_q.lvl <= level;
        end
    end

endmodule

// File: rtl/dtg_duty_meter.sv
module dtg_duty_meter
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic wrap,
    input  logic pwm_in,
    input  lvl_t lvl,
    output dir_e dir_o
);

    cnt_t cnt_q;
    cnt_t total;
    cnt_t thresh;
    dir_e dir_q;
    dir_e dir_nx;

    assign total  = cnt_q + cnt_t'(pwm_in);
    assign thresh = cnt_t'(hi_slots(lvl)) << 1;

    always_comb begin
        if (total > thresh)      dir_nx = DIR_UP;
        else if (total < thresh) dir_nx = DIR_DN;
        else                     dir_nx = DIR_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_HOLD;
        end else if (tick) begin
            if (wrap) begin
                cnt_q <= '0;
                dir_q <= dir_nx;
            end else begin
                cnt_q <= total;
            end
        end
    end

    assign dir_o = dir_q;

endmodule

// File: rtl/dtg_gate_mix.sv
module dtg_gate_mix
    import dtg_pkg::*;
(
    input  frame_t fs,
    input  logic   pwm_in,
    output logic   dig_o,
    output logic   gate_o
);

    logic [SLOT_W-1:0] slot;
    logic              min_pulse;

    assign slot      = fs.phase[PH_W-1:1];
    assign dig_o     = slots_t'(slot) < hi_slots(fs.lvl);
    assign min_pulse = (fs.phase == '0);
    assign gate_o    = (pwm_in & dig_o) | min_pulse;

endmodule

// File: rtl/duty_track_gate.sv
module duty_track_gate
    import dtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [3:0] level,
    input  logic       pwm_in,
    output logic       gate_out,
    output logic [1:0] cmp_dir
);

    frame_t fs;
    logic   wrap;
    logic   dig;
    dir_e   dir;
    phase_t cur_phase;
    lvl_t   cur_lvl;

    assign cur_phase = fs.phase;
    assign cur_lvl   = fs.lvl;

    dtg_frame_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .level  (lvl_t'(level)),
        .fs_o   (fs),
        .wrap_o (wrap)
    );

    dtg_duty_meter u_meter (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .wrap   (wrap),
        .pwm_in (pwm_in),
        .lvl    (fs.lvl),
        .dir_o  (dir)
    );

    dtg_gate_mix u_mix (
        .fs     (fs),
        .pwm_in (pwm_in),
        .dig_o  (dig),
        .gate_o (gate_out)
    );

    assign cmp_dir = dir;

endmodule

// File: rtl/duty_track_gate_chk.sv
module duty_track_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       pwm_in,
    input logic       gate_out,
    input logic [1:0] cmp_dir,
    input logic [4:0] phase,
    input logic [3:0] lvl
);

    a_r6_min_pulse: assert property (@(posedge clk) disable iff (rst)
        (phase == 5'd0) |-> gate_out);

    a_r5_and_block: assert property (@(posedge clk) disable iff (rst)
        (phase != 5'd0 && !pwm_in) |-> !gate_out);

    a_r3_full_pass: assert property (@(posedge clk) disable iff (rst)
        (lvl >= 4'd11 && pwm_in) |-> gate_out);

    a_r2_dig_off: assert property (@(posedge clk) disable iff (rst)
        (lvl < 4'd11 && phase != 5'd0 && ({1'b0, phase[4:1]} >= 5'(lvl) + 5'd5)) |-> !gate_out);

    a_r7_dir_legal: assert property (@(posedge clk) disable iff (rst)
        cmp_dir != 2'b11);

    a_r7_dir_hold: assert property (@(posedge clk) disable iff (rst)
        !(tick && phase == 5'd31) |=> $stable(cmp_dir));

    a_r4_lvl_hold: assert property (@(posedge clk) disable iff (rst)
        !(tick && phase == 5'd31) |=> $stable(lvl));

    a_r8_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase));

endmodule

bind duty_track_gate duty_track_gate_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .pwm_in   (pwm_in),
    .gate_out (gate_out),
    .cmp_dir  (cmp_dir),
    .phase    (cur_phase),
    .lvl      (cur_lvl)
);

// File: tb/test_duty_track_gate.sv
module test_duty_track_gate;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    localparam int WATCHDOG = 100000;

    // {next level, pwm pattern (bit p = phase p)}
    localparam logic [35:0] VEC [NVEC] = '{
        {4'd10, 32'hFFFF_FFFF},
        {4'd0,  32'h0000_0000},
        {4'd11, 32'h0000_03FF},
        {4'd15, 32'hFFFF_FFFF},
        {4'd12, 32'h0000_FFFF},
        {4'd3,  32'hFFFF_0000},
        {4'd7,  32'h00FF_00FF},
        {4'd5,  32'hAAAA_AAAA},
        {4'd1,  32'hFFFF_FF0F},
        {4'd9,  32'h0000_001F}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] level = 4'd0;
    logic       pwm_in = 1'b0;
    logic       gate_out;
    logic [1:0] cmp_dir;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int cur_lvl = 0;
    int last_dir = 0;

    duty_track_gate i_duty_track_gate (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .level    (level),
        .pwm_in   (pwm_in),
        .gate_out (gate_out),
        .cmp_dir  (cmp_dir)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            fails++;
            $display("FAIL watchdog R8: got %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int width_of(input int l);
        return (l + 5 >= 16) ? 16 : l + 5;
    endfunction

    function automatic int exp_dir(input logic [31:0] pat, input int l);
        int n = $countones(pat);
        int t = 2 * width_of(l);
        if (n > t) return 1;
        if (n < t) return 2;
        return 0;
    endfunction

    // one frame: level input scrambled mid-frame, settled to nxt before the close
    task automatic run_frame(input int nxt, input logic [31:0] pat);
        for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            tick = 1'b0;
            pwm_in = pat[p];
            level = (p >= 1 && p <= 20) ? ~nxt[3:0] : nxt[3:0];
            #1;
            if (p == 0)
                chk("R6 min pulse", int'(gate_out), 1);
            else if (cur_lvl >= 11)
                chk("R3 full pattern AND R5", int'(gate_out), int'(pat[p]));
            else
                chk("R2 R4 R5 pattern AND", int'(gate_out),
                    int'(pat[p] && ((p / 2) < width_of(cur_lvl))));
            if (p == 15) chk("R7 dir holds mid-frame", int'(cmp_dir), last_dir);
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
        last_dir = exp_dir(pat, cur_lvl);
        chk("R7 frame compare", int'(cmp_dir), last_dir);
        cur_lvl = nxt;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset dir hold", int'(cmp_dir), 0);
        chk("R1 reset phase 0 min pulse", int'(gate_out), 1);
        pwm_in = 1'b1;
        #1;
        chk("R6 phase 0 with pwm high", int'(gate_out), 1);
        pwm_in = 1'b0;

        for (int i = 0; i < NVEC; i++)
            run_frame(int'(VEC[i][35:32]), VEC[i][31:0]);

        // R8: no tick, nothing moves (phase 0: min pulse visible, dir kept)
        pwm_in = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        chk("R8 phase held without tick", int'(gate_out), 1);
        chk("R8 dir held without tick", int'(cmp_dir), last_dir);

        // R1: reset mid-frame after selecting level 11
        run_frame(11, 32'h0000_FFFF);
        for (int p = 0; p < 7; p++) begin
            @(negedge clk);
            tick = 1'b1;
            pwm_in = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pwm_in = 1'b0;
        #1;
        chk("R1 reset dir cleared", int'(cmp_dir), 0);
        chk("R1 reset phase 0", int'(gate_out), 1);
        last_dir = 0;
        cur_lvl = 0;
        run_frame(4, 32'hFFFF_FFFF);
        run_frame(4, 32'h0000_00FF);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule